// File: doc/BRIEF.md
# PWM Fault Protection Controller

This block sits between a PWM waveform generator and the output pins. It watches eight event channel lines and a debug-break request. When a qualifying fault appears, it forces the PWM outputs into a safe state. A mask register selects which event channels count. The selected channels are OR-combined, so several sources can trip the block at once. A sticky flag records every qualifying fault, and software clears it by writing a 1.

The control register picks three things: the action applied during a fault, whether a debug break counts as a fault, and the restart policy. There are two restart policies.

- **Latched:** the outputs resume only after the fault has gone and software has cleared the flag.
- **Cycle-by-cycle:** the outputs resume as soon as the fault has gone.

In both policies the outputs come back only on a timer UPDATE strobe.

Entry into the fault state is combinational, so the outputs are forced in the same cycle the fault is seen. Exit is registered and happens only on an UPDATE cycle.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset the mask, control and flag read as 0. `pwm_out` equals `pwm_in` and `pwm_oe` is 1.
- R2: The fault condition is the OR of `evt_in & mask`. Register address 0 holds the mask. An event on an unmasked channel has no effect on the outputs or on the flag.
- R3: Any qualifying fault sets the flag one cycle later, whatever the action setting. The flag reads as bit 0 of address 2.
- R4: Writing data bit 0 = 1 to address 2 clears the flag. If a qualifying fault is present in the same cycle, the set wins.
- R5: Control bit 4 = 0 makes a debug break a qualifying fault. Control bit 4 = 1 makes a debug break have no effect.
- R6: Control bits 1:0 select the action.
  - 00 and 10: no effect on the outputs.
  - 01: `pwm_out` is driven all low and `pwm_oe` stays 1.
  - 11: `pwm_oe` goes to 0 and `pwm_out` follows `pwm_in`.
- R7: With an active action, the forcing applies in the same cycle the qualifying fault is present.
- R8: With control bit 2 = 1 (cycle-by-cycle), forcing ends after the first clock edge at which UPDATE is 1 and no fault is present. The flag plays no part.
- R9: With control bit 2 = 0 (latched), forcing ends only after a clock edge at which UPDATE is 1, no fault is present, and the flag already reads 0. An UPDATE that comes earlier leaves the outputs forced.
- R10: Control is at address 1. Only bits 4, 2, 1 and 0 are stored. Bits 7:5 and 3 read as 0 and ignore writes. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | N_EVT | Event channel lines |
| dbg_break | input | 1 | Debug-break request |
| update | input | 1 | Timer UPDATE strobe |
| pwm_in | input | N_PWM | Raw PWM outputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pwm_out | output | N_PWM | Gated PWM outputs |
| pwm_oe | output | 1 | Output enable for the pins |

## Verification
The assertions check several properties on every cycle:
- the flag follows each qualifying fault;
- a release happens only on an UPDATE cycle;
- in latched mode, a release never precedes the flag clear;
- low-forcing and output-enable removal track the action;
- the reserved control bits read as zero.

Some behaviours only the bench scenarios can show. These are an UPDATE that arrives too early and is ignored, the set-over-clear collision, the debug-break disable, and the absence of any effect from unmasked channels and from the inactive action codes. The bench shows them by comparing the ports each cycle against a model built from the requirements.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int N_EVT = 8,
  parameter int N_PWM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             dbg_break,
  input  logic             update,
  input  logic [N_PWM-1:0] pwm_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [N_PWM-1:0] pwm_out,
  output logic             pwm_oe
);
  localparam logic [7:0] CTRL_KEEP = 8'h17;

  logic [N_EVT-1:0] mask_q;
  logic [7:0]       ctrl_q;
  logic             flag_q, trip_q;

  logic [1:0] act;
  logic       act_on, restart_cbc, dbg_ignore, fault_cond, in_fault, flag_clr;

  assign act         = ctrl_q[1:0];
  assign restart_cbc = ctrl_q[2];
  assign dbg_ignore  = ctrl_q[4];
  assign act_on      = act[0];
  assign fault_cond  = (|(evt_in & mask_q)) | (dbg_break & ~dbg_ignore);
  assign in_fault    = trip_q | (fault_cond & act_on);
  assign flag_clr    = wr_en && wr_addr == 2'd2 && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == 2'd0) mask_q <= wr_data[N_EVT-1:0];
      if (wr_addr == 2'd1) ctrl_q <= wr_data & CTRL_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (fault_cond) flag_q <= 1'b1;
    else if (flag_clr)   flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trip_q <= 1'b0;
    else if (fault_cond && act_on)
      trip_q <= 1'b1;
    else if (trip_q && update && !fault_cond && (restart_cbc || !flag_q))
      trip_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = 8'(mask_q);
      2'd1:    rd_data = ctrl_q;
      2'd2:    rd_data = {7'd0, flag_q};
      default: rd_data = 8'd0;
    endcase
  end

  assign pwm_out = (in_fault && act == 2'b01) ? '0 : pwm_in;
  assign pwm_oe  = !(in_fault && act == 2'b11);

  assert_flag_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cond |=> flag_q);
  assert_release_on_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_q) |-> $past(update) && !$past(fault_cond));
  assert_latched_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trip_q) && !$past(restart_cbc)) |-> !$past(flag_q));
  assert_force_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cond && act == 2'b01) |-> (pwm_out == '0 && pwm_oe));
  assert_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cond && act == 2'b11) |-> (!pwm_oe && pwm_out == pwm_in));
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd1) |-> (rd_data[7:5] == 3'd0 && !rd_data[3]));
endmodule

// File: tb/pwm_fault_guard_bench.sv
`timescale 1ns/1ps
module pwm_fault_guard_bench;
  localparam int NE = 8;
  localparam int NP = 4;

  logic clk = 0, rst_n = 0;
  logic [NE-1:0] evt_in = '0;
  logic dbg_break = 0, update = 0, wr_en = 0;
  logic [NP-1:0] pwm_in = '0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NP-1:0] pwm_out;
  logic pwm_oe;

  int checks = 0, failures = 0;
  logic [7:0] m_mask = 0, m_ctrl = 0;
  logic m_flag = 0, m_trip = 0;

  always #5 clk = ~clk;

  pwm_fault_guard #(.N_EVT(NE), .N_PWM(NP)) u_pwm_fault_guard (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .dbg_break(dbg_break),
    .update(update), .pwm_in(pwm_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  function automatic logic fcond();
    return (|(evt_in & m_mask)) | (dbg_break & ~m_ctrl[4]);
  endfunction

  function automatic logic [12:0] expect_ports();
    logic infault;
    logic [NP-1:0] po;
    logic oe;
    logic [7:0] rd;
    infault = m_trip | (fcond() & m_ctrl[0]);
    po = (infault && m_ctrl[1:0] == 2'b01) ? '0 : pwm_in;
    oe = !(infault && m_ctrl[1:0] == 2'b11);
    case (rd_addr)
      2'd0: rd = m_mask;
      2'd1: rd = m_ctrl;
      2'd2: rd = {7'd0, m_flag};
      default: rd = 8'd0;
    endcase
    return {po, oe, rd};
  endfunction

  task automatic tick(input string tag);
    logic [12:0] e;
    logic f;
    #1;
    e = expect_ports();
    checks++;
    if ({pwm_out, pwm_oe, rd_data} !== e) begin
      failures++;
      $display("FAIL %s: got out=%b oe=%b rd=%h exp out=%b oe=%b rd=%h", tag,
               pwm_out, pwm_oe, rd_data, e[12:9], e[8], e[7:0]);
    end
    f = fcond();
    @(posedge clk);
    if (!rst_n) begin
      m_mask = 0; m_ctrl = 0; m_flag = 0; m_trip = 0;
    end else begin
      if (f && m_ctrl[0]) m_trip = 1;
      else if (m_trip && update && !f && (m_ctrl[2] || !m_flag)) m_trip = 0;
      if (f) m_flag = 1;
      else if (wr_en && wr_addr == 2 && wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 0) m_mask = wr_data;
      if (wr_en && wr_addr == 1) m_ctrl = wr_data & 8'h17;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick(tag);
    wr_en = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    pwm_in = 4'b1010;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin rd_addr = 2'(i); tick("R1 reset"); end
    rst_n = 1;
    for (int i = 0; i < 3; i++) begin rd_addr = 2'(i); tick("R1 after reset"); end

    wr(1, 8'hFF, "R10 ctrl write");
    rd_addr = 1; tick("R10 reserved bits read 0");
    rd_addr = 3; tick("R10 addr3 zero");
    wr(0, 8'h04, "R2 mask write");
    wr(1, 8'h01, "R9 latched low setup");
    rd_addr = 2;
    evt_in = 8'h02; tick("R2 unmasked channel");
    tick("R2 unmasked no flag");
    evt_in = 8'h04; pwm_in = 4'b1111; tick("R7 same-cycle entry");
    evt_in = 8'h00; update = 1; tick("R9 update before clear");
    update = 0; tick("R9 still forced");
    evt_in = 8'h04; wr(2, 8'h01, "R4 set wins");
    tick("R4 flag kept");
    evt_in = 8'h00; wr(2, 8'h01, "R4 clear");
    tick("R9 cleared waiting");
    update = 1; tick("R9 release update");
    update = 0; tick("R9 released");

    wr(1, 8'h05, "R8 cbc setup");
    evt_in = 8'h04; tick("R8 fault");
    evt_in = 8'h00; tick("R8 held without update");
    update = 1; tick("R8 update");
    update = 0; tick("R8 released flag still set");

    wr(1, 8'h07, "R6 hiz setup");
    evt_in = 8'h04; pwm_in = 4'b0110; tick("R6 hiz");
    evt_in = 0; update = 1; tick("R6 hiz release");
    update = 0; wr(2, 8'h01, "R3 clear");
    wr(1, 8'h06, "R6 reserved action");
    evt_in = 8'h04; tick("R6 action 10 no effect");
    evt_in = 0; tick("R3 flag set with inactive action");
    wr(1, 8'h04, "R6 action 00");
    evt_in = 8'h04; tick("R6 action 00 no effect");
    evt_in = 0;

    wr(0, 8'h00, "R5 mask off");
    wr(1, 8'h05, "R5 dbg setup");
    dbg_break = 1; tick("R5 debug break faults");
    dbg_break = 0; update = 1; tick("R5 release");
    update = 0; wr(1, 8'h15, "R5 dbg ignore setup");
    wr(2, 8'h01, "R5 clear");
    dbg_break = 1; tick("R5 debug ignored");
    dbg_break = 0; tick("R5 flag untouched");

    for (int i = 0; i < 400; i++) begin
      evt_in = 8'($urandom & $urandom & $urandom);
      dbg_break = ($urandom % 8) == 0;
      update = ($urandom % 4) == 0;
      pwm_in = 4'($urandom);
      rd_addr = 2'($urandom);
      if (($urandom % 6) == 0) begin
        wr_en = 1; wr_addr = 2'($urandom); wr_data = 8'($urandom);
      end
      tick("R2 R3 R4 R6 R8 R9 random");
      wr_en = 0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule